// File: doc/BRIEF.md
# SDRAM Command Sequence Monitor

This block watches the command pins of a four-bank synchronous DRAM and, on every rising clock edge, turns the sampled clock-enable, chip-select, row-strobe, column-strobe, write-enable, bank-address and A10 levels into a named command. The command and its target bank are registered and appear on the outputs one cycle after the edge that sampled them.

Beside decoding, the monitor keeps a small model of each bank: idle, open (active), or open with an auto-precharge burst counting down. It checks each command against that model and against the global rules. These rules cover the precharge state required for mode-register writes and refreshes, the quiet cycle after a mode-register write, and the lockout of the same bank while an auto-precharge burst runs. The first broken rule raises a sticky flag and stores a code that identifies the kind of error. A reset clears the flag and the code.

The burst length is a configuration input. It times the end of each auto-precharge burst, and once that burst ends the bank returns to idle.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With CKE high in the previous and the current sample, the pin levels {cs_n,ras_n,cas_n,we_n} decode as follows. 0000 is MRS (cmd_o=1), 0001 is REF (2), 0011 is ACT (4), 0101 is RD (5), 0100 is WR (6), 0110 is BST (7), 0010 is PRE (8, or PREA=9 when A10 is high) and 0111 is NOP (0). Any sample with cs_n high decodes as NOP. cmd_o shows the command one cycle after its sampling edge.
- R2: If the previous CKE sample was low, the command is NOP. If CKE falls (previous high, current low) with the refresh pin pattern, the command is SREF (cmd_o=3). Any other pattern sampled with CKE falling is NOP.
- R3: bank_o gives the bank index 0..3 from {ba_i[1],ba_i[0]}: 00 gives 0, 10 gives 1, 01 gives 2 and 11 gives 3.
- R4: ACT to an idle bank sets its bit in bank_active_o. ACT to a bank that is already active records violation code 4.
- R5: RD, WR or BST to a bank that is not active records violation code 5.
- R6: PRE with A10 low clears only the selected bank. PRE with A10 high (PREA) clears all banks, whatever the value of ba_i.
- R7: MRS while any bank is active records violation code 1.
- R8: REF or SREF while any bank is active records violation code 2.
- R9: Any command other than NOP in the cycle right after an MRS records violation code 3, which takes priority over the other codes. A NOP in that cycle is legal.
- R10: RD or WR with A10 high to an active bank sets its bit in ap_busy_o. A further RD or WR to that bank during the lockout records violation code 6. The lockout covers the sampling edges 1 to BL after the command. Other banks are not affected.
- R11: burst_len_i selects BL: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. At the BL-th edge after the auto-precharge command, the bank leaves both bank_active_o and ap_busy_o.
- R12: viol_o is sticky until reset. viol_code_o keeps the code of the first violation, and later violations do not change it.
- R13: After reset, cmd_o=0, bank_active_o=0, ap_busy_o=0, viol_o=0 and viol_code_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable pin level |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | 2 | Bank address, ba_i[1]=BA1, ba_i[0]=BA0 |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all-bank select) |
| burst_len_i | input | 2 | Burst length select |
| cmd_o | output | 4 | Decoded command of the last sampled edge |
| bank_o | output | 2 | Target bank index of the last command |
| bank_active_o | output | 4 | One bit per bank, set while the bank is open |
| ap_busy_o | output | 4 | One bit per bank, set while an auto-precharge burst runs |
| viol_o | output | 1 | Sticky violation flag |
| viol_code_o | output | 3 | Code of the first violation |

## Verification
The assertions assume that the pin levels are free of X, that they settle before each rising edge, and that burst_len_i does not change while an auto-precharge burst is counting down. The bench changes every input only on the falling edge. It sets the burst length before opening a bank and keeps it fixed within each scenario. It resets the block between scenarios so that the sticky flag of one scenario does not hide the checks of the next.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int BLSEL_W   = 2;
    localparam int CNT_W     = (1 << BLSEL_W) + 1 > 8 ? 4 : 4;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MRS  = 4'd1,
        CMD_REF  = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_WR   = 4'd6,
        CMD_BST  = 4'd7,
        CMD_PRE  = 4'd8,
        CMD_PREA = 4'd9
    } cmd_e;

    typedef enum logic [2:0] {
        VIOL_NONE      = 3'd0,
        VIOL_MRS_BUSY  = 3'd1,
        VIOL_REF_BUSY  = 3'd2,
        VIOL_MRS_GAP   = 3'd3,
        VIOL_ACT_TWICE = 3'd4,
        VIOL_IDLE_USE  = 3'd5,
        VIOL_AP_LOCK   = 3'd6
    } viol_e;

    typedef struct packed {
        logic             active;
        logic             ap;
        logic [CNT_W-1:0] cnt;
    } bank_state_t;

    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic              cke_prev;
        logic              mrs_last;
        logic              viol;
        viol_e             code;
    } mon_state_t;

    function automatic logic [CNT_W-1:0] burst_cycles(input logic [BLSEL_W-1:0] sel);
        return CNT_W'(1) << sel;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic              cke_prev,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [1:0]        ba,
    input  logic              a10,
    output cmd_e              cmd,
    output logic [BANK_W-1:0] bank
);

    cmd_e raw;

    always_comb begin
        unique case ({ras_n, cas_n, we_n})
            3'b000:  raw = CMD_MRS;
            3'b001:  raw = CMD_REF;
            3'b011:  raw = CMD_ACT;
            3'b101:  raw = CMD_RD;
            3'b100:  raw = CMD_WR;
            3'b110:  raw = CMD_BST;
            3'b010:  raw = a10 ? CMD_PREA : CMD_PRE;
            default: raw = CMD_NOP;
        endcase
    end

    always_comb begin
        cmd = CMD_NOP;
        if (cke_prev && !cs_n) begin
            if (cke)
                cmd = raw;
            else if (raw == CMD_REF)
                cmd = CMD_SREF;
        end
    end

    // Bank index: BA1 is the low index bit, BA0 the high one.
    assign bank = {ba[0], ba[1]};

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_mon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_e               cmd,
    input  logic               sel,
    input  logic               ap_req,
    input  logic [BLSEL_W-1:0] bl_sel,
    output logic               active,
    output logic               ap_busy,
    output logic               err_twice,
    output logic               err_idle,
    output logic               err_lock
);

    bank_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        err_twice = 1'b0;
        err_idle  = 1'b0;
        err_lock  = 1'b0;
        if (st_q.ap) begin
            if (st_q.cnt == CNT_W'(1))
                st_d = '0;
            else
                st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        unique case (cmd)
            CMD_ACT: if (sel) begin
                if (st_q.active) err_twice = 1'b1;
                else             st_d.active = 1'b1;
            end
            CMD_RD, CMD_WR: if (sel) begin
                if (!st_q.active)  err_idle = 1'b1;
                else if (st_q.ap)  err_lock = 1'b1;
                else if (ap_req) begin
                    st_d.ap  = 1'b1;
                    st_d.cnt = burst_cycles(bl_sel);
                end
            end
            CMD_BST: if (sel && !st_q.active) err_idle = 1'b1;
            CMD_PRE: if (sel) st_d = '0;
            CMD_PREA: st_d = '0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign ap_busy = st_q.ap;

    p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT && sel && !active) |=> active);

    p_prea_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PREA) |=> !active);

    p_ap_needs_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ap_busy |-> active);

    p_ap_cnt_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ap_busy |-> (st_q.cnt != '0 && st_q.cnt <= CNT_W'(8)));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cke_i,
    input  logic        cs_n_i,
    input  logic        ras_n_i,
    input  logic        cas_n_i,
    input  logic        we_n_i,
    input  logic [1:0]  ba_i,
    input  logic        a10_i,
    input  logic [1:0]  burst_len_i,
    output logic [3:0]  cmd_o,
    output logic [1:0]  bank_o,
    output logic [3:0]  bank_active_o,
    output logic [3:0]  ap_busy_o,
    output logic        viol_o,
    output logic [2:0]  viol_code_o
);

    mon_state_t            st_d, st_q;
    cmd_e                  dec_cmd;
    logic [BANK_W-1:0]     dec_bank;
    logic [NUM_BANKS-1:0]  act_v, ap_v, e_twice, e_idle, e_lock;
    viol_e                 cur_code;

    sdram_cmd_decode u_dec (
        .cke_prev (st_q.cke_prev),
        .cke      (cke_i),
        .cs_n     (cs_n_i),
        .ras_n    (ras_n_i),
        .cas_n    (cas_n_i),
        .we_n     (we_n_i),
        .ba       (ba_i),
        .a10      (a10_i),
        .cmd      (dec_cmd),
        .bank     (dec_bank)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_bank_fsm u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (dec_cmd),
            .sel       (dec_bank == BANK_W'(b)),
            .ap_req    (a10_i),
            .bl_sel    (burst_len_i),
            .active    (act_v[b]),
            .ap_busy   (ap_v[b]),
            .err_twice (e_twice[b]),
            .err_idle  (e_idle[b]),
            .err_lock  (e_lock[b])
        );
    end

    always_comb begin
        cur_code = VIOL_NONE;
        if (st_q.mrs_last && dec_cmd != CMD_NOP)
            cur_code = VIOL_MRS_GAP;
        else if (dec_cmd == CMD_MRS && |act_v)
            cur_code = VIOL_MRS_BUSY;
        else if ((dec_cmd == CMD_REF || dec_cmd == CMD_SREF) && |act_v)
            cur_code = VIOL_REF_BUSY;
        else if (|e_twice)
            cur_code = VIOL_ACT_TWICE;
        else if (|e_idle)
            cur_code = VIOL_IDLE_USE;
        else if (|e_lock)
            cur_code = VIOL_AP_LOCK;

        st_d          = st_q;
        st_d.cmd      = dec_cmd;
        st_d.bank     = dec_bank;
        st_d.cke_prev = cke_i;
        st_d.mrs_last = (dec_cmd == CMD_MRS);
        if (!st_q.viol && cur_code != VIOL_NONE) begin
            st_d.viol = 1'b1;
            st_d.code = cur_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.cmd      <= CMD_NOP;
            st_q.code     <= VIOL_NONE;
            st_q.cke_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o         = st_q.cmd;
    assign bank_o        = st_q.bank;
    assign bank_active_o = act_v;
    assign ap_busy_o     = ap_v;
    assign viol_o        = st_q.viol;
    assign viol_code_o   = st_q.code;

    p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> (viol_o && $stable(viol_code_o)));

    p_code_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_code_o != 3'd0));

    p_mrs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_cmd == CMD_MRS && |bank_active_o) |=> viol_o);

    p_mrs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd1 && dec_cmd != CMD_NOP) |=> viol_o);

    p_ref_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_cmd == CMD_REF || dec_cmd == CMD_SREF) && |bank_active_o) |=> viol_o);

endmodule

// File: tb/sim_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module sim_sdram_cmd_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic [1:0] ba_i = 2'b00;
    logic       a10_i = 1'b0;
    logic [1:0] burst_len_i = 2'b00;
    logic [3:0] cmd_o;
    logic [1:0] bank_o;
    logic [3:0] bank_active_o, ap_busy_o;
    logic       viol_o;
    logic [2:0] viol_code_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic cke, input logic cs, input logic ras, input logic cas,
                         input logic we, input logic [1:0] bank, input logic a10);
        @(negedge clk);
        cke_i = cke; cs_n_i = cs; ras_n_i = ras; cas_n_i = cas; we_n_i = we;
        ba_i = {bank[0], bank[1]};
        a10_i = a10;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();                                 drive(1, 0, 1, 1, 1, 0, 0);  endtask
    task automatic act(input logic [1:0] b);              drive(1, 0, 0, 1, 1, b, 0);  endtask
    task automatic rd(input logic [1:0] b, input logic ap); drive(1, 0, 1, 0, 1, b, ap); endtask
    task automatic wr(input logic [1:0] b, input logic ap); drive(1, 0, 1, 0, 0, b, ap); endtask
    task automatic bst(input logic [1:0] b);              drive(1, 0, 1, 1, 0, b, 0);  endtask
    task automatic pre(input logic [1:0] b);              drive(1, 0, 0, 1, 0, b, 0);  endtask
    task automatic prea(input logic [1:0] b);             drive(1, 0, 0, 1, 0, b, 1);  endtask
    task automatic mrs();                                 drive(1, 0, 0, 0, 0, 0, 0);  endtask
    task automatic refr();                                drive(1, 0, 0, 0, 1, 0, 0);  endtask

    task automatic do_reset(input logic [1:0] bl);
        @(negedge clk);
        rst_n = 1'b0; burst_len_i = bl;
        cke_i = 1; cs_n_i = 1; ras_n_i = 1; cas_n_i = 1; we_n_i = 1; a10_i = 0; ba_i = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        #1;
        check("R13 cmd", cmd_o, 0);
        check("R13 active", bank_active_o, 0);
        check("R13 ap", ap_busy_o, 0);
        check("R13 viol", viol_o, 0);
        check("R13 code", viol_code_o, 0);
    endtask

    task automatic t_decode();
        do_reset(2'b00);
        drive(1, 1, 0, 0, 0, 0, 0);  check("R1 deselect", cmd_o, 0);
        refr();                      check("R1 refresh", cmd_o, 2);
        act(2'd1);                   check("R1 activate", cmd_o, 4);
                                     check("R3 bank BA1=1", bank_o, 1);
        rd(2'd1, 0);                 check("R1 read", cmd_o, 5);
        wr(2'd1, 0);                 check("R1 write", cmd_o, 6);
        bst(2'd1);                   check("R1 burst stop", cmd_o, 7);
        pre(2'd1);                   check("R1 precharge", cmd_o, 8);
        prea(2'd0);                  check("R1 precharge all", cmd_o, 9);
        mrs();                       check("R1 mode set", cmd_o, 1);
        nop();                       check("R1 nop", cmd_o, 0);
        act(2'd2);                   check("R3 bank BA0=1", bank_o, 2);
        act(2'd3);                   check("R3 bank both", bank_o, 3);
        act(2'd0);                   check("R3 bank none", bank_o, 0);
        check("R1 no violation", viol_o, 0);
    endtask

    task automatic t_cke();
        do_reset(2'b00);
        drive(0, 0, 0, 0, 1, 0, 0);  check("R2 self refresh", cmd_o, 3);
        drive(0, 0, 0, 0, 0, 0, 0);  check("R2 cke low held", cmd_o, 0);
        drive(1, 0, 0, 1, 1, 0, 0);  check("R2 prev cke low", cmd_o, 0);
        check("R2 act ignored", bank_active_o, 0);
        drive(0, 0, 0, 1, 1, 0, 0);  check("R2 cke falling act", cmd_o, 0);
        check("R2 act ignored 2", bank_active_o, 0);
        drive(1, 0, 1, 1, 1, 0, 0);
        nop();
        check("R2 no violation", viol_o, 0);
    endtask

    task automatic t_act();
        do_reset(2'b00);
        act(2'd2);  check("R4 open", bank_active_o, 4'b0100);
        check("R4 no viol", viol_o, 0);
        act(2'd2);  check("R4 double act", viol_code_o, 4);
    endtask

    task automatic t_idle();
        do_reset(2'b00);
        rd(2'd1, 0); check("R5 read idle", viol_code_o, 5);
        do_reset(2'b00);
        bst(2'd3);   check("R5 stop idle", viol_code_o, 5);
        do_reset(2'b00);
        act(2'd0);
        wr(2'd1, 0); check("R5 write idle", viol_code_o, 5);
    endtask

    task automatic t_pre();
        do_reset(2'b00);
        act(2'd0); act(2'd1); act(2'd3);
        check("R6 opened", bank_active_o, 4'b1011);
        pre(2'd1);   check("R6 single", bank_active_o, 4'b1001);
        prea(2'd0);  check("R6 all", bank_active_o, 4'b0000);
        check("R6 no viol", viol_o, 0);
    endtask

    task automatic t_mrs_ref();
        do_reset(2'b00);
        act(2'd0);
        mrs();       check("R7 mrs busy", viol_code_o, 1);
        do_reset(2'b00);
        act(2'd3);
        refr();      check("R8 ref busy", viol_code_o, 2);
        do_reset(2'b00);
        act(2'd1);
        drive(0, 0, 0, 0, 1, 0, 0);
        check("R8 sref busy", viol_code_o, 2);
    endtask

    task automatic t_gap();
        do_reset(2'b00);
        mrs();       check("R9 legal mrs", viol_o, 0);
        nop();       check("R9 nop after mrs", viol_o, 0);
        mrs();
        act(2'd0);   check("R9 gap", viol_code_o, 3);
    endtask

    task automatic t_ap();
        do_reset(2'b01);
        act(2'd0); act(2'd1);
        rd(2'd0, 1); check("R10 ap set", ap_busy_o, 4'b0001);
        wr(2'd1, 0); check("R10 other bank ok", viol_o, 0);
        check("R10 still busy", ap_busy_o, 4'b0001);
        nop();       check("R11 idle after BL2", bank_active_o, 4'b0010);
        check("R11 ap clear", ap_busy_o, 0);
        do_reset(2'b01);
        act(2'd0);
        wr(2'd0, 1);
        nop();
        rd(2'd0, 0); check("R10 lockout last edge", viol_code_o, 6);
        do_reset(2'b00);
        act(2'd2);
        rd(2'd2, 1);
        nop();       check("R11 BL1 idle", bank_active_o, 0);
        do_reset(2'b11);
        act(2'd3);
        rd(2'd3, 1);
        for (int i = 0; i < 7; i++) nop();
        check("R11 BL8 busy", ap_busy_o, 4'b1000);
        nop();       check("R11 BL8 done", bank_active_o, 0);
        check("R11 no viol", viol_o, 0);
    endtask

    task automatic t_sticky();
        do_reset(2'b00);
        act(2'd0); act(2'd0);
        check("R12 first code", viol_code_o, 4);
        rd(2'd2, 0);
        check("R12 code held", viol_code_o, 4);
        nop();
        check("R12 flag held", viol_o, 1);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_cke();
        t_act();
        t_idle();
        t_pre();
        t_mrs_ref();
        t_gap();
        t_ap();
        t_sticky();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule